// File: doc/BRIEF.md
# Command-Driven LCD Sync Generator

This block produces the horizontal and vertical sync levels and a free-running dot clock for a parallel RGB panel. It does not count pixels against comparators. Each stretch of a scan line is a segment, described by a 32-bit command word. The word sets both sync levels, gives the segment length in dot clocks, and names an action that fires when the segment ends. An executor consumes these words over an internal valid/ready handshake. A sequencer inside the block builds the words from programmable porch, pulse and display counts.

The sequencer steps each row through four horizontal phases and tracks the row index. From the row index it chooses the vertical sync level and the end-of-segment actions. The actions appear as one-cycle strobes. The line-start strobe tells a downstream pixel stage to begin a row. The line-fetch and frame-fetch strobes ask a memory mover to queue the next row or frame. While `run` is low, no commands are offered. If a segment ends with nothing queued, the outputs freeze and a sticky underrun flag is set.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset, `dot_clk` is 0, both sync outputs are 1, all strobes are 0 and `underrun` is 0. From then on `dot_clk` inverts on every `clk` cycle, whether or not commands arrive.
- R2: A command word holds the VSYNC level in bit 31, the HSYNC level in bit 30, a 14-bit delay in bits 29..16, and an action in bits 15..0. Action 0x0004 is line start, 0x0001 is line fetch, 0x0002 is frame fetch, and any other value does nothing. Sync outputs change only on the `clk` edge where `dot_clk` falls.
- R3: A segment lasts delay + 3 dot clocks. The sequencer writes each phase length minus 3 into the delay field, and a phase length below 3 acts as 3.
- R4: A row runs front porch, sync pulse, back porch, then display, in that order. `hsync` is low for exactly 2*`h_pulse` clk cycles per row and high for 2*(`h_front`+`h_back`+`h_active`) cycles.
- R5: `vsync` is low while the row index is below `v_pulse`. The low time is `v_pulse` rows and the high time is (`v_total`-`v_pulse`) rows.
- R6: At the end of the back porch, `line_start` pulses only for rows from `v_back` up to `v_active`-1. It comes 2*`h_back` clk cycles after `hsync` rises.
- R7: At the end of the display phase, `frame_fetch` pulses when the row equals `v_active`. Otherwise `line_fetch` pulses for rows from `v_back`-1 up to `v_active`-1. The row index wraps to 0 after `v_total` rows, so `frame_fetch` recurs every `v_total` rows.
- R8: Each strobe is high for a single clk cycle, and at most one strobe is high at a time.
- R9: If a segment ends while no command is offered, `hsync` and `vsync` hold, `dot_clk` keeps toggling, and `underrun` is set until reset. Idling before the first command does not count as an underrun. When `run` returns, the sequence resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the dot rate |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Lets the sequencer offer commands |
| h_front | input | 14 | Front porch length in dot clocks |
| h_pulse | input | 14 | HSYNC pulse length in dot clocks |
| h_back | input | 14 | Back porch length in dot clocks |
| h_active | input | 14 | Display length in dot clocks |
| v_pulse | input | V_W | Rows with VSYNC low |
| v_back | input | V_W | First row that gets a line start |
| v_active | input | V_W | Display limit row |
| v_total | input | V_W | Rows per frame |
| dot_clk | output | 1 | Free-running dot clock |
| hsync | output | 1 | Horizontal sync level |
| vsync | output | 1 | Vertical sync level |
| line_start | output | 1 | Strobe to the pixel stage |
| line_fetch | output | 1 | Strobe: queue next row |
| frame_fetch | output | 1 | Strobe: queue next frame |
| underrun | output | 1 | Sticky missing-command flag |

## Verification
A command is accepted on the clk edge where `dot_clk` falls. The new sync levels and the strobe for the segment that just ended both come out of registers on that same edge, so they are visible one clk cycle after the accepting tick. The bench samples on the falling edge of `clk` and measures every result as a count of those samples between two events. For example, it counts `hsync` low time, the rise of `hsync` to `line_start`, and the gap from one `frame_fetch` to the next. Each expected count is exactly 2 clk cycles per dot clock of the programmed lengths. For underrun, the bench waits longer than the longest segment before it checks that the outputs are frozen.

// File: rtl/lcdsync_pkg.sv
package lcdsync_pkg;
    localparam int DLY_W = 14;
    localparam int ACT_W = 16;
    localparam int CNT_W = DLY_W + 1;

    localparam logic [ACT_W-1:0] ACT_NOP         = 16'h0000;
    localparam logic [ACT_W-1:0] ACT_LINE_FETCH  = 16'h0001;
    localparam logic [ACT_W-1:0] ACT_FRAME_FETCH = 16'h0002;
    localparam logic [ACT_W-1:0] ACT_LINE_START  = 16'h0004;

    typedef struct packed {
        logic             vs;
        logic             hs;
        logic [DLY_W-1:0] delay;
        logic [ACT_W-1:0] action;
    } seg_cmd_t;

    typedef enum logic [1:0] {
        PH_FRONT  = 2'd0,
        PH_PULSE  = 2'd1,
        PH_BACK   = 2'd2,
        PH_ACTIVE = 2'd3
    } hphase_e;

    // Segment runs delay+3 dot clocks; shorter lengths saturate to 3.
    function automatic logic [DLY_W-1:0] len_to_delay(input logic [DLY_W-1:0] len);
        return (len < DLY_W'(3)) ? '0 : DLY_W'(len - DLY_W'(3));
    endfunction
endpackage

// File: rtl/lcdsync_dotclk.sv
module lcdsync_dotclk (
    input  logic clk,
    input  logic rst,
    output logic dot_clk,
    output logic tick
);
    logic dot_q;

    always_ff @(posedge clk) begin
        if (rst) dot_q <= 1'b0;
        else     dot_q <= ~dot_q;
    end

    assign dot_clk = dot_q;
    assign tick    = dot_q;   // edge on which the dot clock falls

    assert_dot_toggle_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (dot_clk != $past(dot_clk)));
endmodule

// File: rtl/lcdsync_seq.sv
module lcdsync_seq
    import lcdsync_pkg::*;
#(
    parameter int V_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DLY_W-1:0] h_front,
    input  logic [DLY_W-1:0] h_pulse,
    input  logic [DLY_W-1:0] h_back,
    input  logic [DLY_W-1:0] h_active,
    input  logic [V_W-1:0]   v_pulse,
    input  logic [V_W-1:0]   v_back,
    input  logic [V_W-1:0]   v_active,
    input  logic [V_W-1:0]   v_total,
    output logic             cmd_valid,
    output seg_cmd_t         cmd,
    input  logic             cmd_ready
);
    localparam int RW = V_W + 1;

    hphase_e        phase_q;
    logic [V_W-1:0] row_q;
    logic           vs_lvl, start_row, fetch_row, last_row, take;

    assign vs_lvl    = (row_q >= v_pulse);
    assign start_row = (row_q >= v_back) && (row_q < v_active);
    assign fetch_row = ((RW'(row_q) + RW'(1)) >= RW'(v_back)) && (row_q < v_active);
    assign last_row  = ((RW'(row_q) + RW'(1)) >= RW'(v_total));
    assign cmd_valid = run;
    assign take      = cmd_valid && cmd_ready;

    always_comb begin
        cmd.vs     = vs_lvl;
        cmd.hs     = 1'b1;
        cmd.delay  = len_to_delay(h_front);
        cmd.action = ACT_NOP;
        case (phase_q)
            PH_PULSE: begin
                cmd.hs    = 1'b0;
                cmd.delay = len_to_delay(h_pulse);
            end
            PH_BACK: begin
                cmd.delay = len_to_delay(h_back);
                if (start_row) cmd.action = ACT_LINE_START;
            end
            PH_ACTIVE: begin
                cmd.delay = len_to_delay(h_active);
                if (row_q == v_active) cmd.action = ACT_FRAME_FETCH;
                else if (fetch_row)    cmd.action = ACT_LINE_FETCH;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FRONT;
            row_q   <= '0;
        end else if (take) begin
            phase_q <= hphase_e'(phase_q + 2'd1);
            if (phase_q == PH_ACTIVE) row_q <= last_row ? '0 : V_W'(row_q + V_W'(1));
        end
    end

    assert_hold_without_handshake_R4: assert property (@(posedge clk) disable iff (rst)
        !take |=> ($stable(phase_q) && $stable(row_q)));
    assert_row_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
        (v_total != '0) |-> (row_q < v_total));
endmodule

// File: rtl/lcdsync_exec.sv
module lcdsync_exec
    import lcdsync_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     cmd_valid,
    input  seg_cmd_t cmd,
    output logic     cmd_ready,
    output logic     hsync,
    output logic     vsync,
    output logic     line_start,
    output logic     line_fetch,
    output logic     frame_fetch,
    output logic     underrun
);
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ACT_W-1:0] act_q;
    logic             seg_done;

    assign seg_done  = !busy_q || (cnt_q == '0);
    assign cmd_ready = tick && seg_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            cnt_q       <= '0;
            act_q       <= ACT_NOP;
            hsync       <= 1'b1;
            vsync       <= 1'b1;
            line_start  <= 1'b0;
            line_fetch  <= 1'b0;
            frame_fetch <= 1'b0;
            underrun    <= 1'b0;
        end else begin
            line_start  <= 1'b0;
            line_fetch  <= 1'b0;
            frame_fetch <= 1'b0;
            if (tick) begin
                if (seg_done) begin
                    if (busy_q) begin
                        line_start  <= (act_q == ACT_LINE_START);
                        line_fetch  <= (act_q == ACT_LINE_FETCH);
                        frame_fetch <= (act_q == ACT_FRAME_FETCH);
                    end
                    if (cmd_valid) begin
                        busy_q <= 1'b1;
                        cnt_q  <= CNT_W'(cmd.delay) + CNT_W'(2);
                        act_q  <= cmd.action;
                        hsync  <= cmd.hs;
                        vsync  <= cmd.vs;
                    end else begin
                        busy_q <= 1'b0;
                        if (busy_q) underrun <= 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end

    assert_strobe_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({line_start, line_fetch, frame_fetch}));
    assert_line_start_single_R8: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start);
    assert_frame_fetch_single_R8: assert property (@(posedge clk) disable iff (rst)
        frame_fetch |=> !frame_fetch);
    assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);
    assert_sync_on_low_half_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick)) |-> ($stable(hsync) && $stable(vsync)));
    assert_accept_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> tick);
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
    import lcdsync_pkg::*;
#(
    parameter int V_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DLY_W-1:0] h_front,
    input  logic [DLY_W-1:0] h_pulse,
    input  logic [DLY_W-1:0] h_back,
    input  logic [DLY_W-1:0] h_active,
    input  logic [V_W-1:0]   v_pulse,
    input  logic [V_W-1:0]   v_back,
    input  logic [V_W-1:0]   v_active,
    input  logic [V_W-1:0]   v_total,
    output logic             dot_clk,
    output logic             hsync,
    output logic             vsync,
    output logic             line_start,
    output logic             line_fetch,
    output logic             frame_fetch,
    output logic             underrun
);
    logic     tick, cmd_valid, cmd_ready;
    seg_cmd_t cmd;

    lcdsync_dotclk u_dotclk (
        .clk(clk), .rst(rst), .dot_clk(dot_clk), .tick(tick)
    );

    lcdsync_seq #(.V_W(V_W)) u_seq (
        .clk(clk), .rst(rst), .run(run),
        .h_front(h_front), .h_pulse(h_pulse), .h_back(h_back), .h_active(h_active),
        .v_pulse(v_pulse), .v_back(v_back), .v_active(v_active), .v_total(v_total),
        .cmd_valid(cmd_valid), .cmd(cmd), .cmd_ready(cmd_ready)
    );

    lcdsync_exec u_exec (
        .clk(clk), .rst(rst), .tick(tick),
        .cmd_valid(cmd_valid), .cmd(cmd), .cmd_ready(cmd_ready),
        .hsync(hsync), .vsync(vsync),
        .line_start(line_start), .line_fetch(line_fetch), .frame_fetch(frame_fetch),
        .underrun(underrun)
    );
endmodule

// File: tb/tb_lcd_sync_gen.sv
module tb_lcd_sync_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [13:0] h_front, h_pulse, h_back, h_active;
    logic [11:0] v_pulse, v_back, v_active, v_total;
    logic        dot_clk, hsync, vsync, line_start, line_fetch, frame_fetch, underrun;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lcd_sync_gen dut (
        .clk(clk), .rst(rst), .run(run),
        .h_front(h_front), .h_pulse(h_pulse), .h_back(h_back), .h_active(h_active),
        .v_pulse(v_pulse), .v_back(v_back), .v_active(v_active), .v_total(v_total),
        .dot_clk(dot_clk), .hsync(hsync), .vsync(vsync),
        .line_start(line_start), .line_fetch(line_fetch), .frame_fetch(frame_fetch),
        .underrun(underrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int w);
        return (w == 0) ? hsync : vsync;
    endfunction

    function automatic int row_clk();
        return 2 * (int'(h_front) + int'(h_pulse) + int'(h_back) + int'(h_active));
    endfunction

    task automatic start(input int fp, input int hp, input int bp, input int ad,
                         input int vp, input int vb, input int va, input int vt, input bit go);
        @(negedge clk);
        rst = 1'b1; run = go;
        h_front = 14'(fp); h_pulse = 14'(hp); h_back = 14'(bp); h_active = 14'(ad);
        v_pulse = 12'(vp); v_back = 12'(vb); v_active = 12'(va); v_total = 12'(vt);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // low and high times in clk cycles of hsync (w=0) or vsync (w=1)
    task automatic measure(input int w, output int low, output int high);
        low = 0; high = 0;
        for (int i = 0; i < 5000 && pick(w) != 1'b1; i++) @(negedge clk);
        for (int i = 0; i < 5000 && pick(w) != 1'b0; i++) @(negedge clk);
        while (pick(w) == 1'b0 && low < 5000) begin low++; @(negedge clk); end
        while (pick(w) == 1'b1 && high < 5000) begin high++; @(negedge clk); end
    endtask

    task automatic t_reset_state();
        start(4, 3, 5, 8, 2, 4, 8, 10, 1'b1);
        chk(dot_clk == 1'b0, "R1 dot_clk after reset", int'(dot_clk), 0);
        chk(hsync == 1'b1 && vsync == 1'b1, "R1 sync after reset", int'({vsync, hsync}), 3);
        chk({line_start, line_fetch, frame_fetch, underrun} == 4'b0, "R1 flags after reset",
            int'({line_start, line_fetch, frame_fetch, underrun}), 0);
        begin
            int bad = 0;
            logic prev;
            prev = dot_clk;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (dot_clk == prev) bad++;
                prev = dot_clk;
            end
            chk(bad == 0, "R1 dot_clk toggles each cycle", bad, 0);
        end
    endtask

    task automatic t_hsync(input string tag);
        int lo, hi;
        measure(0, lo, hi);
        chk(lo == 2 * int'(h_pulse), {"R4 hsync low ", tag}, lo, 2 * int'(h_pulse));
        chk(hi == 2 * (int'(h_front) + int'(h_back) + int'(h_active)), {"R4 hsync high ", tag},
            hi, 2 * (int'(h_front) + int'(h_back) + int'(h_active)));
    endtask

    task automatic t_vsync(input string tag);
        int lo, hi;
        measure(1, lo, hi);
        chk(lo == int'(v_pulse) * row_clk(), {"R5 vsync low ", tag}, lo, int'(v_pulse) * row_clk());
        chk(hi == (int'(v_total) - int'(v_pulse)) * row_clk(), {"R5 vsync high ", tag},
            hi, (int'(v_total) - int'(v_pulse)) * row_clk());
    endtask

    task automatic t_strobes(input string tag);
        int frame, ls, lf, ff_mid, ff_end, ls_hi, multi;
        logic prev_ls;
        frame = int'(v_total) * row_clk();
        ls = 0; lf = 0; ff_mid = 0; ff_end = 0; ls_hi = 0; multi = 0; prev_ls = 1'b0;
        for (int i = 0; i < 5000 && !frame_fetch; i++) @(negedge clk);
        for (int i = 1; i <= frame; i++) begin
            @(negedge clk);
            if (line_start && !prev_ls) ls++;
            if (line_start) ls_hi++;
            if (line_fetch) lf++;
            if (int'(line_start) + int'(line_fetch) + int'(frame_fetch) > 1) multi++;
            if (frame_fetch && i < frame) ff_mid++;
            if (i == frame) ff_end = int'(frame_fetch);
            prev_ls = line_start;
        end
        chk(ls == int'(v_active) - int'(v_back), {"R6 line_start per frame ", tag},
            ls, int'(v_active) - int'(v_back));
        chk(lf == int'(v_active) - int'(v_back) + 1, {"R7 line_fetch per frame ", tag},
            lf, int'(v_active) - int'(v_back) + 1);
        chk(ff_mid == 0 && ff_end == 1, {"R7 frame_fetch period ", tag}, ff_mid * 10 + ff_end, 1);
        chk(ls_hi == ls && multi == 0, {"R8 strobe width and exclusion ", tag}, ls_hi * 100 + multi, ls * 100);
    endtask

    task automatic t_line_start_timing();
        int c, found;
        found = 0; c = 0;
        for (int r = 0; r < 40 && found == 0; r++) begin
            for (int i = 0; i < 5000 && hsync != 1'b0; i++) @(negedge clk);
            for (int i = 0; i < 5000 && hsync != 1'b1; i++) @(negedge clk);
            c = 0;
            for (int i = 0; i < 2 * int'(h_back) + 4 && found == 0; i++) begin
                if (line_start) found = 1;
                else begin c++; @(negedge clk); end
            end
        end
        chk(found == 1 && c == 2 * int'(h_back), "R6 line_start after hsync rise", c, 2 * int'(h_back));
    endtask

    task automatic t_clamp();
        int lo, hi;
        start(4, 1, 5, 8, 2, 4, 8, 10, 1'b1);
        measure(0, lo, hi);
        chk(lo == 6, "R3 short pulse saturates to 3 dots", lo, 6);
        chk(hi == 34, "R3 other phases unchanged", hi, 34);
    endtask

    task automatic t_idle_start();
        start(4, 3, 5, 8, 2, 4, 8, 10, 1'b0);
        repeat (30) @(negedge clk);
        chk(underrun == 1'b0, "R9 no underrun before first command", int'(underrun), 0);
        chk(hsync == 1'b1 && vsync == 1'b1, "R9 idle sync levels", int'({vsync, hsync}), 3);
    endtask

    task automatic t_underrun();
        logic h0, v0;
        int changes, toggles, seen_low;
        logic prev;
        start(4, 3, 5, 8, 2, 4, 8, 10, 1'b1);
        repeat (57) @(negedge clk);
        run = 1'b0;
        repeat (60) @(negedge clk);
        chk(underrun == 1'b1, "R9 underrun set", int'(underrun), 1);
        h0 = hsync; v0 = vsync; changes = 0; toggles = 0; prev = dot_clk;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (hsync != h0 || vsync != v0) changes++;
            if (dot_clk != prev) toggles++;
            prev = dot_clk;
        end
        chk(changes == 0, "R9 sync held while starved", changes, 0);
        chk(toggles == 40, "R9 dot_clk keeps running", toggles, 40);
        run = 1'b1;
        seen_low = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!hsync) seen_low = 1;
        end
        chk(seen_low == 1, "R9 sequence resumes", seen_low, 1);
        chk(underrun == 1'b1, "R9 underrun sticky", int'(underrun), 1);
    endtask

    initial begin
        #(100000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_hsync("cfg1");
        t_vsync("cfg1");
        t_strobes("cfg1");
        t_line_start_timing();
        start(3, 5, 3, 6, 1, 2, 5, 7, 1'b1);
        t_hsync("cfg2");
        t_vsync("cfg2");
        t_strobes("cfg2");
        t_line_start_timing();
        t_clamp();
        t_idle_start();
        t_underrun();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule